// File: doc/BRIEF.md
# Packet Page Allocator with Queues

This block keeps track of a small pool of fixed-size packet buffer pages inside a network controller. It owns a bitmap of which pages are in use, plus three queues of page numbers: one for receive, one for transmit and one for transmit completions. It never sees packet bytes. Host software steers it through a command byte whose top three bits pick an operation: allocate for transmit, pop or pop-and-free the receive head, free a selected page, queue a selected page for transmit, clear the transmit side, or reset everything. The result of the last transmit allocation, the heads of the receive and completion queues, and the number of pages in use are all visible as plain outputs.

There are two streams. The receive side offers `rx_push_valid`/`rx_push_ready`. Ready is high only when a free page exists, the receive queue has room, no command is being applied in that cycle and no pending transmit allocation is being retried. A transfer happens on a clock edge where both are high. It claims the page shown on `rx_push_page`, which is always the lowest-numbered free page. The transmit side offers `tx_out_valid`/`tx_out_ready`. While `tx_en` is high and the transmit queue is not empty, the head page is presented and held until it is accepted. Each accepted page is either freed or appended to the completion queue.

An interrupt status byte and a mask byte sit next to the queues, and `irq` is high whenever the two overlap. A transmit allocation that finds no free page leaves the result at 0x80. It completes by itself in the first command-free cycle after a page becomes free.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset the status is 0x04, the mask is 0x00, the allocation result is 0x00, both queue heads read 0x80, no page is in use and `irq` is low.
- R2: Command code 1 (byte 0x20) claims the lowest-numbered free page. The page number goes to the allocation result, status bit 3 (allocation done) is set, and the in-use count rises by one.
- R3: When command code 1 finds no free page, the result becomes 0x80 and status bit 3 clears. The request stays pending. It completes on the first clock edge with no command that follows the freeing of a page (code 5, code 4 or auto-release), and receive pushes are held off during that edge.
- R4: `rx_push_ready` is high only when a page is free, the receive queue has room, `cmd_valid` is low and no retry is due. An accepted push claims the lowest free page, appends it to the receive queue and sets status bit 0.
- R5: Code 3 (0x60) pops the receive queue. Code 4 (0x80) pops it and frees the popped page. After a pop, status bit 0 stays set if entries remain and clears if the queue became empty. Either pop on an empty queue changes nothing.
- R6: Code 5 (0xA0) frees the page on `page_sel`. Code 6 (0xC0) appends `page_sel` to the transmit queue. A push to a full queue is dropped.
- R7: While `tx_en` is high, the transmit queue is drained in order, one page per accepted handshake. With `auto_rel` high each sent page is freed. Otherwise it is appended to the completion queue, or dropped if that queue is full.
- R8: Code 7 (0xE0) empties the transmit and completion queues. Code 2 (0x40) empties all queues, frees every page, sets the result to 0x00 and cancels a pending allocation.
- R9: Status bit 2 is set whenever the transmit queue is empty, and bit 1 whenever the completion queue is not empty. An acknowledge write clears the status bits in (byte AND 0xD6). An acknowledge with bit 1 set also pops the completion queue.
- R10: `irq` equals the OR-reduction of (status AND mask). The mask is loaded by a mask write.
- R11: A queue head output reads 0x80 when its queue is empty and the zero-extended page number otherwise.
- R12: Code 0 (0x00 to 0x1F) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte is applied on this edge |
| cmd_byte | input | 8 | Command; bits 7:5 select the operation |
| page_sel | input | PW | Page used by free and transmit-push commands |
| ack_valid | input | 1 | Acknowledge write strobe |
| ack_byte | input | 8 | Acknowledge value |
| mask_we | input | 1 | Mask write strobe |
| mask_byte | input | 8 | New mask value |
| tx_en | input | 1 | Allow the transmit queue to drain |
| auto_rel | input | 1 | Free sent pages instead of logging completion |
| rx_push_valid | input | 1 | Receive side requests a page |
| rx_push_ready | output | 1 | A page can be granted this cycle |
| rx_push_page | output | PW | Page granted on a receive handshake |
| tx_out_valid | output | 1 | Transmit head page is offered |
| tx_out_ready | input | 1 | Sender accepts the offered page |
| tx_out_page | output | PW | Offered transmit page |
| alloc_result | output | 8 | Last transmit allocation result, 0x80 while pending |
| rx_head | output | 8 | Receive queue head or 0x80 |
| done_head | output | 8 | Completion queue head or 0x80 |
| used_pages | output | CW | Number of pages in use |
| irq_status | output | 8 | Interrupt status bits |
| irq_mask | output | 8 | Interrupt mask bits |
| irq | output | 1 | Interrupt request |

## Verification
Commands, acknowledges, mask writes and stream handshakes all take effect on the edge where they are sampled. Their results therefore show up on the registered outputs one edge later, and the bench drives on the falling edge and reads on the next falling edge. The offer on `tx_out_valid`/`tx_out_page`, the receive grant on `rx_push_ready`/`rx_push_page` and the `irq` line are combinational from registered state, so they are read in the same half-cycle in which the state that feeds them settles. A retried allocation completes one edge after the edge that frees a page. The bench therefore checks for 0x80 right after the freeing command and for the page number one cycle later.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;
  typedef enum logic [2:0] {
    OP_NOP         = 3'd0,
    OP_TX_ALLOC    = 3'd1,
    OP_RESET       = 3'd2,
    OP_RX_POP      = 3'd3,
    OP_RX_POP_FREE = 3'd4,
    OP_FREE        = 3'd5,
    OP_TX_PUSH     = 3'd6,
    OP_TX_CLR      = 3'd7
  } mmu_op_e;

  localparam logic [7:0] EMPTY_CODE = 8'h80;
  localparam logic [7:0] ACK_MASK   = 8'hD6;
  localparam int IRQ_RCV      = 0;
  localparam int IRQ_TX       = 1;
  localparam int IRQ_TX_EMPTY = 2;
  localparam int IRQ_ALLOC    = 3;
endpackage

// File: rtl/page_queue.sv
module page_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         empty_nx
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt, cnt_nx;
  logic          do_pop, do_push;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign head    = slots[rd_ptr];
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_comb begin
    cnt_nx = cnt;
    if (clr)
      cnt_nx = '0;
    else if (do_push && !do_pop)
      cnt_nx = cnt + 1'b1;
    else if (do_pop && !do_push)
      cnt_nx = cnt - 1'b1;
  end

  assign empty_nx = (cnt_nx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      cnt <= cnt_nx;
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push) wr_ptr <= bump(wr_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) slots[wr_ptr] <= push_data;
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_full_push_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
endmodule

// File: rtl/page_pool.sv
module page_pool #(
  parameter int NPG = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       take,
  input  logic [NPG-1:0]             free_mask,
  output logic                       has_free,
  output logic [$clog2(NPG)-1:0]     low_page,
  output logic [$clog2(NPG+1)-1:0]   used
);
  localparam int PW = $clog2(NPG);
  localparam int CW = $clog2(NPG + 1);

  logic [NPG-1:0] in_use;
  logic [NPG-1:0] take_mask;

  always_comb begin
    low_page = '0;
    for (int i = NPG - 1; i >= 0; i--)
      if (!in_use[i]) low_page = PW'(i);
  end

  always_comb begin
    used = '0;
    for (int i = 0; i < NPG; i++)
      used = used + CW'(in_use[i]);
  end

  assign has_free  = ~&in_use;
  assign take_mask = (take && has_free) ? (NPG'(1) << low_page) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      in_use <= '0;
    else
      in_use <= (in_use & ~free_mask) | take_mask;
  end

  p_take_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> has_free);
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_mask));
  p_take_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr && !free_mask[low_page]) |=> in_use[$past(low_page)]);
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pkt_alloc_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PW = $clog2(NUM_PAGES),
  localparam int CW = $clog2(NUM_PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic [PW-1:0] page_sel,
  input  logic          ack_valid,
  input  logic [7:0]    ack_byte,
  input  logic          mask_we,
  input  logic [7:0]    mask_byte,
  input  logic          tx_en,
  input  logic          auto_rel,
  input  logic          rx_push_valid,
  output logic          rx_push_ready,
  output logic [PW-1:0] rx_push_page,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [PW-1:0] tx_out_page,
  output logic [7:0]    alloc_result,
  output logic [7:0]    rx_head,
  output logic [7:0]    done_head,
  output logic [CW-1:0] used_pages,
  output logic [7:0]    irq_status,
  output logic [7:0]    irq_mask,
  output logic          irq
);
  mmu_op_e op;
  logic op_alloc, op_reset, op_rxpop, op_rxfree, op_free, op_txpush, op_txclr;
  logic has_free, take, retry_now, alloc_now, pending;
  logic rx_fire, tx_fire, rx_pop;
  logic [PW-1:0] low_page, rxq_head, txq_head, cq_head;
  logic rxq_empty, rxq_full, rxq_empty_nx;
  logic txq_empty, txq_full, txq_empty_nx;
  logic cq_empty, cq_full, cq_empty_nx;
  logic [NUM_PAGES-1:0] free_mask;
  logic [7:0] status_nx;

  function automatic logic [NUM_PAGES-1:0] page_bit(input logic [PW-1:0] p);
    return NUM_PAGES'(1) << p;
  endfunction

  function automatic logic [7:0] head_code(input logic e, input logic [PW-1:0] p);
    return e ? EMPTY_CODE : {{(8-PW){1'b0}}, p};
  endfunction

  assign op        = mmu_op_e'(cmd_byte[7:5]);
  assign op_alloc  = cmd_valid && (op == OP_TX_ALLOC);
  assign op_reset  = cmd_valid && (op == OP_RESET);
  assign op_rxpop  = cmd_valid && (op == OP_RX_POP);
  assign op_rxfree = cmd_valid && (op == OP_RX_POP_FREE);
  assign op_free   = cmd_valid && (op == OP_FREE);
  assign op_txpush = cmd_valid && (op == OP_TX_PUSH);
  assign op_txclr  = cmd_valid && (op == OP_TX_CLR);

  // allocation arbitration: command, then retry, then receive stream
  assign alloc_now     = op_alloc && has_free;
  assign retry_now     = pending && has_free && !cmd_valid;
  assign rx_push_ready = !cmd_valid && !retry_now && has_free && !rxq_full;
  assign rx_push_page  = low_page;
  assign rx_fire       = rx_push_valid && rx_push_ready;
  assign take          = alloc_now || retry_now || rx_fire;

  assign tx_out_valid = tx_en && !txq_empty;
  assign tx_out_page  = txq_head;
  assign tx_fire      = tx_out_valid && tx_out_ready;
  assign rx_pop       = op_rxpop || op_rxfree;

  always_comb begin
    free_mask = '0;
    if (op_free)                 free_mask = free_mask | page_bit(page_sel);
    if (op_rxfree && !rxq_empty) free_mask = free_mask | page_bit(rxq_head);
    if (tx_fire && auto_rel)     free_mask = free_mask | page_bit(txq_head);
  end

  page_pool #(.NPG(NUM_PAGES)) u_pool (
    .clk(clk), .rst_n(rst_n), .clr(op_reset), .take(take),
    .free_mask(free_mask), .has_free(has_free), .low_page(low_page),
    .used(used_pages)
  );

  page_queue #(.DEPTH(NUM_PAGES), .W(PW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(op_reset), .push(rx_fire),
    .push_data(low_page), .pop(rx_pop), .head(rxq_head),
    .empty(rxq_empty), .full(rxq_full), .empty_nx(rxq_empty_nx)
  );

  page_queue #(.DEPTH(NUM_PAGES), .W(PW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(op_reset || op_txclr), .push(op_txpush),
    .push_data(page_sel), .pop(tx_fire), .head(txq_head),
    .empty(txq_empty), .full(txq_full), .empty_nx(txq_empty_nx)
  );

  page_queue #(.DEPTH(NUM_PAGES), .W(PW)) u_cq (
    .clk(clk), .rst_n(rst_n), .clr(op_reset || op_txclr),
    .push(tx_fire && !auto_rel), .push_data(txq_head),
    .pop(ack_valid && ack_byte[IRQ_TX]), .head(cq_head),
    .empty(cq_empty), .full(cq_full), .empty_nx(cq_empty_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || op_reset) begin
      alloc_result <= 8'h00;
      pending      <= 1'b0;
    end else if (op_alloc) begin
      alloc_result <= has_free ? {{(8-PW){1'b0}}, low_page} : EMPTY_CODE;
      pending      <= !has_free;
    end else if (retry_now) begin
      alloc_result <= {{(8-PW){1'b0}}, low_page};
      pending      <= 1'b0;
    end
  end

  always_comb begin
    status_nx = irq_status;
    if (ack_valid)               status_nx = status_nx & ~(ack_byte & ACK_MASK);
    if (op_alloc)                status_nx[IRQ_ALLOC] = 1'b0;
    if (alloc_now || retry_now)  status_nx[IRQ_ALLOC] = 1'b1;
    if (rx_pop && !rxq_empty)    status_nx[IRQ_RCV] = !rxq_empty_nx;
    if (rx_fire)                 status_nx[IRQ_RCV] = 1'b1;
    if (txq_empty_nx)            status_nx[IRQ_TX_EMPTY] = 1'b1;
    if (!cq_empty_nx)            status_nx[IRQ_TX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_status <= 8'h04;
      irq_mask   <= 8'h00;
    end else begin
      irq_status <= status_nx;
      if (mask_we) irq_mask <= mask_byte;
    end
  end

  assign irq       = |(irq_status & irq_mask);
  assign rx_head   = head_code(rxq_empty, rxq_head);
  assign done_head = head_code(cq_empty, cq_head);

  p_alloc_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_alloc && !has_free) |=> (alloc_result == EMPTY_CODE));
  p_retry_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    retry_now |=> (alloc_result != EMPTY_CODE) && irq_status[IRQ_ALLOC]);
  p_rx_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_ready |-> !rxq_full && !cmd_valid);
  p_rcv_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rxq_empty |-> irq_status[IRQ_RCV]);
  p_drain_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid |-> tx_en);
  p_offer_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready && tx_en && !cmd_valid) |=> tx_out_valid && $stable(tx_out_page));
  p_txempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txq_empty |-> irq_status[IRQ_TX_EMPTY]);
  p_txdone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cq_empty |-> irq_status[IRQ_TX]);
endmodule

// File: tb/tb_pkt_page_alloc.sv
module tb_pkt_page_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int PW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n, cmd_valid, ack_valid, mask_we, tx_en, auto_rel;
  logic rx_push_valid, rx_push_ready, tx_out_valid, tx_out_ready, irq;
  logic [7:0] cmd_byte, ack_byte, mask_byte, alloc_result, rx_head, done_head;
  logic [7:0] irq_status, irq_mask;
  logic [PW-1:0] page_sel, rx_push_page, tx_out_page;
  logic [CW-1:0] used_pages;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_page_alloc #(.NUM_PAGES(NP)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .page_sel(page_sel), .ack_valid(ack_valid), .ack_byte(ack_byte),
    .mask_we(mask_we), .mask_byte(mask_byte), .tx_en(tx_en), .auto_rel(auto_rel),
    .rx_push_valid(rx_push_valid), .rx_push_ready(rx_push_ready),
    .rx_push_page(rx_push_page), .tx_out_valid(tx_out_valid),
    .tx_out_ready(tx_out_ready), .tx_out_page(tx_out_page),
    .alloc_result(alloc_result), .rx_head(rx_head), .done_head(done_head),
    .used_pages(used_pages), .irq_status(irq_status), .irq_mask(irq_mask), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 0; cmd_byte = 0; page_sel = 0;
    ack_valid = 0; ack_byte = 0; mask_we = 0; mask_byte = 0;
    tx_en = 0; auto_rel = 0; rx_push_valid = 0; tx_out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_cmd(input logic [7:0] b, input logic [PW-1:0] sel);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b; page_sel = sel;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_ack(input logic [7:0] b);
    @(negedge clk);
    ack_valid = 1'b1; ack_byte = b;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic do_mask(input logic [7:0] b);
    @(negedge clk);
    mask_we = 1'b1; mask_byte = b;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R1", "status", irq_status, 8'h04);
    check("R1", "mask", irq_mask, 8'h00);
    check("R1", "result", alloc_result, 8'h00);
    check("R1", "used", used_pages, 0);
    check("R1", "irq", irq, 0);
    check("R11", "rx head empty", rx_head, 8'h80);
    check("R11", "done head empty", done_head, 8'h80);
  endtask

  task automatic t_alloc_and_retry();
    do_reset();
    for (int i = 0; i < NP; i++) begin
      do_cmd(8'h20, 0);
      check("R2", "alloc page", alloc_result, i);
      check("R2", "used count", used_pages, i + 1);
      check("R2", "alloc bit", irq_status[3], 1);
    end
    do_cmd(8'h00, 0);
    check("R12", "noop result", alloc_result, 3);
    do_cmd(8'h1F, 2);
    check("R12", "noop used", used_pages, 4);
    check("R12", "noop status", irq_status, 8'h0C);
    do_cmd(8'h20, 0);
    check("R3", "fail code", alloc_result, 8'h80);
    check("R3", "alloc bit cleared", irq_status[3], 0);
    do_cmd(8'hA0, 2);
    check("R6", "free drops count", used_pages, 3);
    check("R3", "still pending", alloc_result, 8'h80);
    check("R3", "rx held during retry", rx_push_ready, 0);
    @(negedge clk);
    check("R3", "retried page", alloc_result, 2);
    check("R3", "alloc bit after retry", irq_status[3], 1);
    check("R3", "used after retry", used_pages, 4);
    check("R4", "ready low when pool full", rx_push_ready, 0);
    do_cmd(8'h40, 0);
    check("R8", "reset result", alloc_result, 8'h00);
    check("R8", "reset used", used_pages, 0);
  endtask

  task automatic t_rx();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_push_valid = 1'b1;
      #1;
      check("R4", "rx ready", rx_push_ready, 1);
      check("R4", "rx grant page", rx_push_page, i);
      @(negedge clk);
      rx_push_valid = 1'b0;
    end
    check("R4", "rx head", rx_head, 0);
    check("R4", "rcv bit", irq_status, 8'h05);
    check("R4", "rx used", used_pages, 3);
    do_cmd(8'h60, 0);
    check("R5", "pop head", rx_head, 1);
    check("R5", "rcv kept", irq_status[0], 1);
    check("R5", "pop keeps page", used_pages, 3);
    do_cmd(8'h80, 0);
    check("R5", "pop-free head", rx_head, 2);
    check("R5", "pop-free used", used_pages, 2);
    do_cmd(8'h80, 0);
    check("R5", "emptied head", rx_head, 8'h80);
    check("R5", "rcv cleared", irq_status, 8'h04);
    check("R5", "used after last", used_pages, 1);
    do_cmd(8'h60, 0);
    check("R5", "empty pop head", rx_head, 8'h80);
    check("R5", "empty pop used", used_pages, 1);
    check("R5", "empty pop status", irq_status, 8'h04);
  endtask

  task automatic t_tx_complete();
    do_reset();
    do_cmd(8'hC0, 0);
    do_cmd(8'hC0, 1);
    check("R9", "tx empty sticky", irq_status, 8'h04);
    do_ack(8'h04);
    check("R9", "ack clears tx empty", irq_status, 8'h00);
    @(negedge clk);
    tx_en = 1'b1;
    #1;
    check("R7", "offer first", tx_out_valid, 1);
    check("R7", "offer page 0", tx_out_page, 0);
    tx_out_ready = 1'b1;
    @(negedge clk);
    check("R7", "offer page 1", tx_out_page, 1);
    @(negedge clk);
    check("R7", "drained", tx_out_valid, 0);
    tx_en = 1'b0; tx_out_ready = 1'b0;
    check("R7", "done head", done_head, 0);
    check("R9", "tx and empty bits", irq_status, 8'h06);
    do_mask(8'h02);
    check("R10", "irq on tx", irq, 1);
    do_ack(8'h02);
    check("R9", "ack pops done", done_head, 1);
    check("R9", "tx bit resets", irq_status, 8'h06);
    do_ack(8'h02);
    check("R9", "done empty", done_head, 8'h80);
    check("R9", "tx bit gone", irq_status, 8'h04);
    check("R10", "irq masked off", irq, 0);
    do_mask(8'hFF);
    check("R10", "irq all mask", irq, 1);
  endtask

  task automatic t_auto_release();
    do_reset();
    do_cmd(8'h20, 0);
    do_cmd(8'h20, 0);
    auto_rel = 1'b1; tx_en = 1'b1; tx_out_ready = 1'b1;
    do_cmd(8'hC0, 1);
    @(negedge clk);
    check("R7", "auto release used", used_pages, 1);
    check("R7", "no completion", done_head, 8'h80);
    tx_en = 1'b0; tx_out_ready = 1'b0; auto_rel = 1'b0;
  endtask

  task automatic t_tx_full();
    int got;
    logic [PW-1:0] exp_pg;
    do_reset();
    do_cmd(8'hC0, 0);
    do_cmd(8'hC0, 1);
    do_cmd(8'hC0, 2);
    do_cmd(8'hC0, 3);
    do_cmd(8'hC0, 2);
    got = 0;
    @(negedge clk);
    tx_en = 1'b1; tx_out_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      #1;
      if (tx_out_valid) begin
        exp_pg = PW'(got);
        check("R6", "drain order", tx_out_page, exp_pg);
        got++;
      end
      @(negedge clk);
    end
    tx_en = 1'b0; tx_out_ready = 1'b0;
    check("R6", "full push dropped", got, 4);
    check("R7", "completion head", done_head, 0);
    do_cmd(8'hE0, 0);
    check("R8", "tx clear done head", done_head, 8'h80);
  endtask

  initial begin
    t_reset();
    t_alloc_and_retry();
    t_rx();
    t_tx_complete();
    t_auto_release();
    t_tx_full();
    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule